// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block steps the two least significant address bits through a four-beat burst. An access starts when the active-low start strobe is sampled low at a rising clock edge. At that edge the block captures the full address. The upper bits are held unchanged for the rest of the burst. The low two bits seed a two-bit wraparound beat counter.

Each later edge that sees the active-low advance input low, with no start, moves the burst to its next beat. The order of the beats is set by an order-select pin, which is sampled at the start edge. A low level gives linear (modulo-4 increment) order. A high level gives interleaved (start XOR beat index) order. The pin has a weak pull-up, so a pin left unconnected gives interleaved order.

A flag marks the fourth beat of the burst. Advancing past that beat wraps the burst back to its first address; the counter does not stall.

Top module: `burst_addr_gen`

## Requirements
- R1: While the asynchronous active-low reset is held, `addr_out` is all zeros and `last_beat` is 0.
- R2: At a rising edge with `start_n` low, the block captures the full `addr_in` and resets the beat index to 0. From the next cycle, `addr_out` equals the captured address and `last_beat` is 0.
- R3: At an edge with both `start_n` and `adv_n` high, `addr_out` and `last_beat` keep their values.
- R4: With `order_sel` low at the start edge, beat k (k = 0..3) puts (start + k) mod 4 on `addr_out[1:0]`. For example, start 2 gives 2, 3, 0, 1.
- R5: With `order_sel` high at the start edge, beat k puts (start XOR k) on `addr_out[1:0]`. For example, start 1 gives 1, 0, 3, 2.
- R6: An instance whose `order_sel` pin is left unconnected produces interleaved order, as in R5.
- R7: `last_beat` is 1 exactly while the beat index is 3, the fourth beat of the burst.
- R8: An advance taken on the fourth beat returns `addr_out[1:0]` to the start value and clears `last_beat`.
- R9: When `start_n` and `adv_n` are both low at the same edge, the start wins. The counter reloads from `addr_in` and the beat index becomes 0.
- R10: A change of `order_sel` in the middle of a burst does not change the order of that burst.
- R11: When `start_n` is high, changes on `addr_in` do not affect `addr_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low burst start strobe |
| adv_n | input | 1 | Active-low advance to the next beat |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved; pulled up when left open |
| addr_in | input | ADDR_W | Address captured at the start of a burst |
| addr_out | output | ADDR_W | Held upper bits joined with the current low beat address |
| last_beat | output | 1 | High on the fourth beat of the burst |

## Verification
Every result is registered. A start or an advance sampled at one rising edge shows on `addr_out` and `last_beat` after that edge, so the result is due one cycle after the stimulus. The driver changes inputs on the falling edge. After the following rising edge it pushes the expected address and flag for both instances into a queue. The monitor pops and compares each item on the next falling edge, half a period after the outputs have settled.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic              adv_n,
  input  tri1               order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_beat
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      base_q;
  logic [1:0]      beat_q;
  logic            ilv_q;
  logic [1:0]      lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= 2'd0;
      beat_q <= 2'd0;
      ilv_q  <= 1'b1;
    end else if (!start_n) begin
      hi_q   <= addr_in[ADDR_W-1:2];
      base_q <= addr_in[1:0];
      beat_q <= 2'd0;
      ilv_q  <= order_sel;
    end else if (!adv_n) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign lo        = ilv_q ? (base_q ^ beat_q) : (base_q + beat_q);
  assign addr_out  = {hi_q, lo};
  assign last_beat = (beat_q == 2'd3);

  // R2: a start loads the full address on the next cycle
  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n |=> (addr_out == $past(addr_in)) && !last_beat);

  // R3: no start and no advance keeps the outputs
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && adv_n) |=> ($stable(addr_out) && $stable(last_beat)));

  // R4: a linear advance steps the low bits by one, modulo 4
  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && !adv_n && !ilv_q) |=> (addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)));

  // R8: an advance on the last beat wraps and clears the flag
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && !adv_n && last_beat) |=> !last_beat);

  // R9: a start together with an advance still reloads
  a_r9_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_n && !adv_n) |=> (addr_out[1:0] == $past(addr_in[1:0])));

  // R11: upper bits move only on a start
  a_r11_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    start_n |=> $stable(addr_out[ADDR_W-1:2]));
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1;
  logic adv_n = 1'b1;
  logic order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out, addr_out1;
  logic last_beat, last_beat1;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .adv_n(adv_n),
    .order_sel(order_sel), .addr_in(addr_in),
    .addr_out(addr_out), .last_beat(last_beat));

  burst_addr_gen #(.ADDR_W(AW)) u1 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .adv_n(adv_n),
    .order_sel(), .addr_in(addr_in),
    .addr_out(addr_out1), .last_beat(last_beat1));

  typedef struct {
    logic [AW-1:0] a0;
    logic          l0;
    logic [AW-1:0] a1;
    string         req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [AW-3:0] m_hi = '0;
  logic [1:0] m_base = 2'd0, m_beat = 2'd0;
  logic m_ilv = 1'b1;

  function automatic logic [1:0] lo_of(input logic ilv, input logic [1:0] b, input logic [1:0] k);
    return ilv ? (b ^ k) : 2'(b + k);
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic s_n, input logic a_n, input logic [AW-1:0] a,
                      input logic mode, input string req);
    exp_t e;
    @(negedge clk);
    start_n = s_n; adv_n = a_n; addr_in = a; order_sel = mode;
    @(posedge clk);
    if (!s_n) begin
      m_hi = a[AW-1:2]; m_base = a[1:0]; m_beat = 2'd0; m_ilv = mode;
    end else if (!a_n) begin
      m_beat = m_beat + 2'd1;
    end
    #1;
    e.a0  = {m_hi, lo_of(m_ilv, m_base, m_beat)};
    e.l0  = (m_beat == 2'd3);
    e.a1  = {m_hi, lo_of(1'b1, m_base, m_beat)};
    e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.req, " addr"}, addr_out, e.a0);
      check({e.req, " last"}, {{(AW-1){1'b0}}, last_beat}, {{(AW-1){1'b0}}, e.l0});
      check({e.req, " open-pin addr (R6)"}, addr_out1, e.a1);
      check({e.req, " open-pin last (R7)"}, {{(AW-1){1'b0}}, last_beat1}, {{(AW-1){1'b0}}, e.l0});
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    check("R1 addr", addr_out, '0);
    check("R1 last", {{(AW-1){1'b0}}, last_beat}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R4/R7/R8: linear burst from 2, then wrap
    step(1'b0, 1'b1, 17'h1A5F6, 1'b0, "R2 linear start");
    step(1'b1, 1'b0, 17'h00000, 1'b0, "R4 beat1");
    step(1'b1, 1'b0, 17'h00000, 1'b0, "R4 beat2");
    step(1'b1, 1'b0, 17'h00000, 1'b0, "R7 beat3 last");
    step(1'b1, 1'b0, 17'h00000, 1'b0, "R8 wrap");
    // R3/R11: holds, address input changes ignored
    step(1'b1, 1'b1, 17'h1FFFF, 1'b0, "R3 hold");
    step(1'b1, 1'b1, 17'h0ABCD, 1'b1, "R11 addr ignored");

    // R5: interleaved burst from 1
    step(1'b0, 1'b1, 17'h05551, 1'b1, "R5 start");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 17'h00000, 1'b1, "R5 advance");

    // R10: mode flips mid-burst, linear from 3 continues
    step(1'b0, 1'b1, 17'h12343, 1'b0, "R10 start");
    step(1'b1, 1'b0, 17'h00000, 1'b1, "R10 beat1");
    step(1'b1, 1'b0, 17'h00000, 1'b1, "R10 beat2");
    step(1'b1, 1'b1, 17'h00000, 1'b1, "R10 hold");
    step(1'b1, 1'b0, 17'h00000, 1'b0, "R10 beat3");

    // R9: start with advance, and restart mid-burst
    step(1'b0, 1'b0, 17'h0F00E, 1'b1, "R9 both low");
    step(1'b1, 1'b0, 17'h00000, 1'b1, "R9 beat1");
    step(1'b0, 1'b0, 17'h00F01, 1'b0, "R9 restart");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 17'h00000, 1'b0, "R4 linear from 1");
    // interleaved from 3 with hold between beats
    step(1'b0, 1'b1, 17'h1C003, 1'b1, "R5 start 3");
    step(1'b1, 1'b0, 17'h00000, 1'b1, "R5 beat1");
    step(1'b1, 1'b1, 17'h00000, 1'b1, "R3 mid hold");
    step(1'b1, 1'b0, 17'h00000, 1'b1, "R5 beat2");
    step(1'b1, 1'b0, 17'h00000, 1'b1, "R7 beat3");

    @(negedge clk); start_n = 1'b1; adv_n = 1'b1;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule